// File: doc/BRIEF.md
# Array Bus Sequencing Controller

This block is a small programmable sequencer for a processing-element array that sits behind one shared bus. A host first writes a short program into the block's program store. It then pulses `start`. The controller steps through the program, one instruction at a time. Each instruction does one of four things:

- pushes an operand into one addressed element register, taking it either from an incoming external word stream or from a local register file;
- pulls a result word back from one addressed element into the register file;
- jumps when a host flag is set;
- stops the run.

The register file keeps words that are used again, so they do not have to be fetched a second time. Each register-file entry holds a data word and a 2-bit status. All three data paths are valid/ready streams:

- **Array write bus.** A word moves when `bw_valid` and `bw_ready` are both high at a rising edge. Once `bw_valid` is high, the bus address, data and tag stay frozen until that edge.
- **External source.** When a load takes its operand from the external stream, the stream is passed straight through. `ext_ready` simply mirrors `bw_ready`, and back-pressure from the array reaches the source within the same cycle.
- **Result return.** `rx_ready` stays high, with the element address on `rx_sel`, until the element answers with `rx_valid`.

While a transfer is stalled by back-pressure, the program counter holds.

Top module: `abus_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `bw_valid`, `rx_ready` and `ext_ready` are low. Every register-file entry holds data 0 and status 00, which a load from the register file shows as `bw_data`=0 and `bw_tag`=00.
- R2: Program words are written through `cfg_we`/`cfg_addr`/`cfg_word` only while no program is running (idle or done). A write made while a program runs has no effect.
- R3: A `start` pulse while idle or done begins execution at word 0. A HALT raises `done`, drops `busy`, and ends all bus activity until the next `start`.
- R4: Instruction word (24 bits):
  - bits [23:22] hold the opcode: 00 LOAD, 01 RECV, 10 BRANCH, 11 HALT;
  - bits [21:16] hold the register-file index;
  - bits [15:8] hold the element address;
  - bits [7:0] hold the branch target.
  For LOAD, bit 0 selects the source: 1 for the external stream, 0 for the register file.
- R5: For every LOAD, the element address is on `bw_addr` for at least one cycle before `bw_valid` rises. It stays stable until the transfer completes.
- R6: A LOAD from the register file puts the indexed entry's data on `bw_data` and its status on `bw_tag`.
- R7: A LOAD from the external stream forwards `ext_data` with `bw_tag`=01. `bw_valid` follows `ext_valid`, and `ext_ready` follows `bw_ready`. `ext_ready` is never high outside such a load.
- R8: A RECV raises `rx_ready` with the element address on `rx_sel`. On the `rx_valid` handshake, `rx_data` is stored into the indexed entry with status 01.
- R9: LOAD and RECV stall until their handshake completes, and the program counter advances only after it. Transfers occur in program order, with no loss and no duplication.
- R10: BRANCH jumps to the target when `host_flag` is 1 and goes to the next word when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Program store write strobe |
| cfg_addr | input | 8 | Program store word address |
| cfg_word | input | 24 | Instruction word to store |
| start | input | 1 | Begin execution at word 0 |
| host_flag | input | 1 | Branch condition from the host |
| ext_valid | input | 1 | External operand stream valid |
| ext_ready | output | 1 | External operand stream ready |
| ext_data | input | 32 | External operand word |
| bw_valid | output | 1 | Array write bus valid |
| bw_ready | input | 1 | Array write bus ready |
| bw_addr | output | 8 | Target element-register address |
| bw_data | output | 32 | Word written to the element |
| bw_tag | output | 2 | Status carried with the word |
| rx_ready | output | 1 | Controller awaits a result |
| rx_valid | input | 1 | Element result valid |
| rx_sel | output | 8 | Element whose result is awaited |
| rx_data | input | 32 | Result word from the element |
| busy | output | 1 | A program is running |
| done | output | 1 | Last run ended on HALT |

## Verification
The stall assertions rely on two properties of the inputs:
- the external source never withdraws `ext_valid` or changes `ext_data` before `ext_ready` accepts the word;
- an element, once it raises `rx_valid`, holds it until the handshake.

The stimulus keeps to both rules. It raises each external word only once and keeps it until acceptance, even while array back-pressure toggles `bw_ready`. Its element model answers after a fixed latency and drops `rx_valid` only on the cycle after the handshake. Program words are written only while the controller is idle or done, except for the one deliberate write made during a stalled run.

// File: rtl/abus_seq_pkg.sv
package abus_seq_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'b00,
    OP_RECV   = 2'b01,
    OP_BRANCH = 2'b10,
    OP_HALT   = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_ADDR,
    ST_DATA,
    ST_RECV,
    ST_DONE
  } st_e;

  localparam logic [1:0] TAG_EMPTY = 2'b00;
  localparam logic [1:0] TAG_VALID = 2'b01;
endpackage

// File: rtl/abus_seq_progmem.sv
module abus_seq_progmem #(
  parameter int IW   = 24,
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PC_W-1:0] waddr,
  input  logic [IW-1:0]   wdata,
  input  logic [PC_W-1:0] raddr,
  output logic [IW-1:0]   rdata
);
  localparam int DEPTH = 1 << PC_W;

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/abus_seq_regfile.sv
module abus_seq_regfile #(
  parameter int DW    = 32,
  parameter int SW    = 2,
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  input  logic [SW-1:0]    wstat,
  output logic [DW-1:0]    rdata,
  output logic [SW-1:0]    rstat
);
  logic [DW-1:0] data_q [DEPTH];
  logic [SW-1:0] stat_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        data_q[i] <= '0;
        stat_q[i] <= '0;
      end
    end else if (we) begin
      data_q[idx] <= wdata;
      stat_q[idx] <= wstat;
    end
  end

  assign rdata = data_q[idx];
  assign rstat = stat_q[idx];
endmodule

// File: rtl/abus_seq_addrgen.sv
module abus_seq_addrgen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [AW-1:0] next_addr,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (issue) addr <= next_addr;
  end
endmodule

// File: rtl/abus_seq.sv
module abus_seq
  import abus_seq_pkg::*;
#(
  parameter int DW       = 32,
  parameter int SW       = 2,
  parameter int RF_DEPTH = 64,
  parameter int AW       = 8,
  parameter int PC_W     = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [PC_W-1:0]                      cfg_addr,
  input  logic [2+$clog2(RF_DEPTH)+AW+PC_W-1:0] cfg_word,
  input  logic                                 start,
  input  logic                                 host_flag,
  input  logic                                 ext_valid,
  output logic                                 ext_ready,
  input  logic [DW-1:0]                        ext_data,
  output logic                                 bw_valid,
  input  logic                                 bw_ready,
  output logic [AW-1:0]                        bw_addr,
  output logic [DW-1:0]                        bw_data,
  output logic [SW-1:0]                        bw_tag,
  output logic                                 rx_ready,
  input  logic                                 rx_valid,
  output logic [AW-1:0]                        rx_sel,
  input  logic [DW-1:0]                        rx_data,
  output logic                                 busy,
  output logic                                 done
);
  localparam int RF_AW = $clog2(RF_DEPTH);
  localparam int IW    = 2 + RF_AW + AW + PC_W;

  st_e              st, st_nxt;
  logic [PC_W-1:0]  pc, pc_nxt;
  logic [IW-1:0]    instr;
  op_e              op;
  logic [RF_AW-1:0] f_idx;
  logic [AW-1:0]    f_elem;
  logic [PC_W-1:0]  f_tgt;
  logic             src_ext;
  logic             ag_issue;
  logic [AW-1:0]    ag_addr;
  logic             rf_we;
  logic [DW-1:0]    rf_rdata;
  logic [SW-1:0]    rf_rstat;
  logic             cfg_open;

  // Program store may only change while nothing runs
  assign cfg_open = (st == ST_IDLE) || (st == ST_DONE);

  abus_seq_progmem #(.IW(IW), .PC_W(PC_W)) u_prog (
    .clk   (clk),
    .we    (cfg_we && cfg_open),
    .waddr (cfg_addr),
    .wdata (cfg_word),
    .raddr (pc),
    .rdata (instr)
  );

  assign op      = op_e'(instr[IW-1 -: 2]);
  assign f_idx   = instr[IW-3 -: RF_AW];
  assign f_elem  = instr[PC_W+AW-1 -: AW];
  assign f_tgt   = instr[PC_W-1:0];
  assign src_ext = f_tgt[0];

  abus_seq_regfile #(.DW(DW), .SW(SW), .DEPTH(RF_DEPTH), .IDX_W(RF_AW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .idx   (f_idx),
    .wdata (rx_data),
    .wstat (SW'(TAG_VALID)),
    .rdata (rf_rdata),
    .rstat (rf_rstat)
  );

  abus_seq_addrgen #(.AW(AW)) u_ag (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (ag_issue),
    .next_addr (f_elem),
    .addr      (ag_addr)
  );

  always_comb begin
    st_nxt    = st;
    pc_nxt    = pc;
    ag_issue  = 1'b0;
    rf_we     = 1'b0;
    bw_valid  = 1'b0;
    ext_ready = 1'b0;
    rx_ready  = 1'b0;
    case (st)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          st_nxt = ST_RUN;
          pc_nxt = '0;
        end
      end
      ST_RUN: begin
        case (op)
          OP_LOAD:   begin ag_issue = 1'b1; st_nxt = ST_ADDR; end
          OP_RECV:   begin ag_issue = 1'b1; st_nxt = ST_RECV; end
          OP_BRANCH: pc_nxt = host_flag ? f_tgt : pc + PC_W'(1);
          default:   st_nxt = ST_DONE;
        endcase
      end
      ST_ADDR: st_nxt = ST_DATA;
      ST_DATA: begin
        bw_valid  = src_ext ? ext_valid : 1'b1;
        ext_ready = src_ext && bw_ready;
        if (bw_valid && bw_ready) begin
          pc_nxt = pc + PC_W'(1);
          st_nxt = ST_RUN;
        end
      end
      ST_RECV: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          rf_we  = 1'b1;
          pc_nxt = pc + PC_W'(1);
          st_nxt = ST_RUN;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      pc <= '0;
    end else begin
      st <= st_nxt;
      pc <= pc_nxt;
    end
  end

  assign bw_addr = ag_addr;
  assign rx_sel  = ag_addr;
  assign bw_data = src_ext ? ext_data : rf_rdata;
  assign bw_tag  = src_ext ? SW'(TAG_VALID) : rf_rstat;
  assign busy    = !cfg_open;
  assign done    = (st == ST_DONE);

  // R5
  addr_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bw_valid) |-> $stable(bw_addr));

  // R5
  bw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_valid && !bw_ready) |=> (bw_valid && $stable(bw_addr) && $stable(bw_data) && $stable(bw_tag)));

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rx_valid) |=> (rx_ready && $stable(rx_sel)));

  // R9
  pc_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bw_valid && !bw_ready) || (rx_ready && !rx_valid)) |=> $stable(pc));

  // R3
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bw_valid && !rx_ready && !ext_ready && !busy));

  // R7
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ready |-> (bw_valid == ext_valid) && bw_ready);
endmodule

// File: tb/sim_abus_seq.sv
`timescale 1ns/1ps
module sim_abus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [23:0] cfg_word = '0;
  logic        start = 1'b0;
  logic        host_flag = 1'b0;
  logic        ext_valid = 1'b0;
  logic        ext_ready;
  logic [31:0] ext_data = '0;
  logic        bw_valid;
  logic        bw_ready = 1'b1;
  logic [7:0]  bw_addr;
  logic [31:0] bw_data;
  logic [1:0]  bw_tag;
  logic        rx_ready;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_sel;
  logic [31:0] rx_data = '0;
  logic        busy, done;

  always #2.5 clk = ~clk;

  abus_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_word(cfg_word),
    .start(start), .host_flag(host_flag), .ext_valid(ext_valid), .ext_ready(ext_ready),
    .ext_data(ext_data), .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr),
    .bw_data(bw_data), .bw_tag(bw_tag), .rx_ready(rx_ready), .rx_valid(rx_valid),
    .rx_sel(rx_sel), .rx_data(rx_data), .busy(busy), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rdy_mode = 0;
  logic ext_gap = 1'b0;
  logic [41:0] exp_q [$];
  logic [31:0] ext_words [4];
  int   ext_idx = 0;

  function automatic logic [23:0] enc(input logic [1:0] op, input logic [5:0] idx,
                                      input logic [7:0] el, input logic [7:0] tg);
    return {op, idx, el, tg};
  endfunction

  function automatic logic [31:0] elem_val(input logic [7:0] s);
    return {s, ~s, s ^ 8'h3C, 8'h96};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_w(input logic [7:0] a, input logic [31:0] d, input logic [1:0] t);
    exp_q.push_back({a, t, d});
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [23:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_run();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    check(seen && !busy, req, {62'd0, busy, done}, 64'd1);
    check(exp_q.size() == 0, "R9 all expected writes seen", exp_q.size(), 0);
  endtask

  // bus-side agent and scoreboard monitor
  initial begin
    logic prev_v = 1'b0;
    logic [7:0] prev_a = '0;
    bit ext_acc = 0, rx_acc = 0;
    int rx_wait = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (ext_acc) begin ext_valid = 1'b0; ext_idx++; ext_acc = 0; end
      if (rx_acc) begin rx_valid = 1'b0; rx_wait = 0; rx_acc = 0; end
      if (rx_ready && !rx_valid) begin
        rx_wait++;
        if (rx_wait >= 2) begin rx_valid = 1'b1; rx_data = elem_val(rx_sel); end
      end
      bw_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? cyc[0] : 1'b0;
      if (!ext_valid && ext_idx < 4 && (!ext_gap || cyc[1])) begin
        ext_valid = 1'b1;
        ext_data  = ext_words[ext_idx];
      end
      #1;
      if (rst_n && bw_valid && !prev_v)
        check(bw_addr == prev_a, "R5 address ahead of valid", bw_addr, prev_a);
      if (rst_n && bw_valid && bw_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected bus write", {bw_addr, bw_tag, bw_data}, 0);
        end else begin
          logic [41:0] e;
          e = exp_q.pop_front();
          check({bw_addr, bw_tag, bw_data} == e, "R6/R7/R9 bus write", {bw_addr, bw_tag, bw_data}, e);
        end
      end
      prev_v = bw_valid;
      prev_a = bw_addr;
      if (ext_valid && ext_ready) ext_acc = 1;
      if (rx_valid && rx_ready) rx_acc = 1;
    end
  end

  task automatic finish_sim();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    finish_sim();
  end

  initial begin
    ext_words[0] = 32'hDEADBEEF;
    ext_words[1] = 32'h11112222;
    ext_words[2] = 32'h33334444;
    ext_words[3] = 32'h55556666;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done, "R1 idle after reset", {busy, done}, 0);
    check(!bw_valid && !rx_ready && !ext_ready, "R1 no bus activity", {bw_valid, rx_ready, ext_ready}, 0);

    // R1 R6: register file cleared, status 00
    cfg_write(8'd0, enc(2'b00, 6'd5, 8'h12, 8'h00));
    cfg_write(8'd1, enc(2'b11, 6'd0, 8'h00, 8'h00));
    expect_w(8'h12, 32'h0, 2'b00);
    start_run();
    wait_done("R3 halt after reset-state load");

    // R8 R6 R7 R4: receive, reuse, external load
    cfg_write(8'd0, enc(2'b01, 6'd3,  8'h21, 8'h00));
    cfg_write(8'd1, enc(2'b01, 6'd63, 8'h44, 8'h00));
    cfg_write(8'd2, enc(2'b00, 6'd3,  8'h80, 8'h00));
    cfg_write(8'd3, enc(2'b00, 6'd0,  8'h07, 8'h01));
    cfg_write(8'd4, enc(2'b00, 6'd63, 8'hFF, 8'h00));
    cfg_write(8'd5, enc(2'b11, 6'd0,  8'h00, 8'h00));
    expect_w(8'h80, elem_val(8'h21), 2'b01);
    expect_w(8'h07, 32'hDEADBEEF, 2'b01);
    expect_w(8'hFF, elem_val(8'h44), 2'b01);
    start_run();
    wait_done("R8 receive then reuse run");

    // R10 branch taken
    cfg_write(8'd0, enc(2'b10, 6'd0, 8'h00, 8'd3));
    cfg_write(8'd1, enc(2'b00, 6'd3, 8'h01, 8'h00));
    cfg_write(8'd2, enc(2'b11, 6'd0, 8'h00, 8'h00));
    cfg_write(8'd3, enc(2'b00, 6'd3, 8'h02, 8'h00));
    cfg_write(8'd4, enc(2'b11, 6'd0, 8'h00, 8'h00));
    host_flag = 1'b1;
    expect_w(8'h02, elem_val(8'h21), 2'b01);
    start_run();
    wait_done("R10 branch taken");
    // R10 not taken, R3 restart from word 0
    host_flag = 1'b0;
    expect_w(8'h01, elem_val(8'h21), 2'b01);
    start_run();
    wait_done("R3 R10 restart, branch not taken");

    // R7 R9 back-pressure and source gaps
    rdy_mode = 1;
    ext_gap  = 1'b1;
    cfg_write(8'd0, enc(2'b00, 6'd0,  8'h10, 8'h01));
    cfg_write(8'd1, enc(2'b00, 6'd0,  8'h11, 8'h01));
    cfg_write(8'd2, enc(2'b00, 6'd63, 8'h12, 8'h00));
    cfg_write(8'd3, enc(2'b00, 6'd0,  8'h13, 8'h01));
    cfg_write(8'd4, enc(2'b11, 6'd0,  8'h00, 8'h00));
    expect_w(8'h10, 32'h11112222, 2'b01);
    expect_w(8'h11, 32'h33334444, 2'b01);
    expect_w(8'h12, elem_val(8'h44), 2'b01);
    expect_w(8'h13, 32'h55556666, 2'b01);
    start_run();
    wait_done("R9 stalled stream run");
    check(ext_idx == 4, "R7 all external words consumed", ext_idx, 4);

    // R2 program write while running is ignored; R9 stall holds
    rdy_mode = 2;
    ext_gap  = 1'b0;
    cfg_write(8'd0, enc(2'b00, 6'd3, 8'h30, 8'h00));
    cfg_write(8'd1, enc(2'b11, 6'd0, 8'h00, 8'h00));
    expect_w(8'h30, elem_val(8'h21), 2'b01);
    start_run();
    repeat (4) @(negedge clk);
    #1;
    check(busy && bw_valid && bw_addr == 8'h30, "R9 held during stall", {busy, bw_valid, bw_addr}, {1'b1, 1'b1, 8'h30});
    cfg_write(8'd1, enc(2'b00, 6'd3, 8'h31, 8'h00));
    rdy_mode = 0;
    wait_done("R2 write during run ignored");
    check(!ext_ready && !rx_ready, "R3 quiet after halt", {ext_ready, rx_ready}, 0);

    finish_sim();
  end
endmodule